// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit ports, called A and B, and can pass data in either direction. Each port has its own storage register. The A register is loaded from the A port on the rising edge of one load clock, and the B register is loaded from the B port on the rising edge of a second load clock. Whichever port is driving can carry one of two values: the live data arriving on the opposite port, or the value held in that opposite port's register. In both cases the data is inverted bit by bit on its way through.

An active-low enable and a direction input decide which port, if any, drives. While the enable is high, both ports only listen. The registers still load on their clock edges during that time, so data can be parked and forwarded later. Each bidirectional pin is split into an input vector, an output vector and a single output-enable per port. The surrounding pad logic combines these into a tri-state pin.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is 0, both storage registers are cleared to zero at once, without a clock. With the stored source selected, each output then reads all ones, because the path inverts.
- R2: The A register takes the value of `a_in` on each rising edge of `a_cap_clk`. A rising edge of `b_cap_clk` leaves it unchanged.
- R3: The B register takes the value of `b_in` on each rising edge of `b_cap_clk`. A rising edge of `a_cap_clk` leaves it unchanged.
- R4: While `en_n` is 1 (isolation), `a_oe` and `b_oe` are both 0, whatever `dir_a2b` is.
- R5: While `en_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R6: `b_out` is the bitwise complement of `a_in` when `b_sel_stored` = 0, and the bitwise complement of the A register when `b_sel_stored` = 1.
- R7: `a_out` is the bitwise complement of `b_in` when `a_sel_stored` = 0, and the bitwise complement of the B register when `a_sel_stored` = 1.
- R8: Both registers keep loading on their clock edges while in isolation. A value stored there appears on the driving port once that port is enabled with its stored source selected.
- R9: A change of either select input, or of live input data, reaches the output in the same cycle, with no clock edge needed.
- R10: `a_oe` and `b_oe` are never both 1, for any combination of `en_n` and `dir_a2b`.
- R11: While one port drives, the other port is an input. Its data can be loaded into its register in the same cycle that its live value is being forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of both registers |
| a_cap_clk | input | 1 | Rising edge loads the A register from `a_in` |
| b_cap_clk | input | 1 | Rising edge loads the B register from `b_in` |
| en_n | input | 1 | Active-low output enable; 1 means isolation |
| dir_a2b | input | 1 | 1: B port driven from A data; 0: A port driven from B data |
| b_sel_stored | input | 1 | Source for `b_out`: 0 live `a_in`, 1 A register |
| a_sel_stored | input | 1 | Source for `a_out`: 0 live `b_in`, 1 B register |
| a_in | input | 8 | A port input data |
| a_out | output | 8 | A port output data (inverted) |
| a_oe | output | 1 | A port output enable |
| b_in | input | 8 | B port input data |
| b_out | output | 8 | B port output data (inverted) |
| b_oe | output | 1 | B port output enable |

## Verification
Two functions can fall in the same cycle: loading a register from the listening port, and forwarding that port's live data through the other port. The bench provokes this by driving the B port from A with the live source selected. It changes `a_in` and raises `a_cap_clk` together. It then checks that the live output follows the new input, and that the stored value taken at that edge appears once the select flips to the stored source. A second case loads both registers on a shared edge during isolation and then reads each one back through its own direction.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

   // Which port, if any, is driving.
   typedef enum logic [1:0] {
      XCVR_ISOLATE = 2'b00,
      XCVR_A_TO_B  = 2'b01,
      XCVR_B_TO_A  = 2'b10
   } xcvr_mode_e;

   // Source of a driven port's data.
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } xcvr_src_e;

   function automatic xcvr_mode_e decode_mode(input logic en_n, input logic dir_a2b);
      if (en_n)
         return XCVR_ISOLATE;
      else if (dir_a2b)
         return XCVR_A_TO_B;
      else
         return XCVR_B_TO_A;
   endfunction

endpackage

// File: rtl/regbus_capture_reg.sv
module regbus_capture_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] CLEAR_VAL = '0;

   initial begin
      assert (WIDTH >= 1) else $error("regbus_capture_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= CLEAR_VAL;
      else
         q <= d;
   end

endmodule

// File: rtl/regbus_path_mux.sv
module regbus_path_mux #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             sel_stored,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] y
);

   import regbus_xcvr_pkg::*;

   logic [WIDTH-1:0] picked;
   xcvr_src_e        src;

   initial begin
      assert (WIDTH >= 1) else $error("regbus_path_mux: WIDTH must be at least 1");
   end

   assign src = xcvr_src_e'(sel_stored);

   always_comb begin
      case (src)
         SRC_STORED: picked = stored;
         default:    picked = live;
      endcase
   end

   generate
      if (INVERT) begin : g_invert
         assign y = ~picked;
      end else begin : g_true
         assign y = picked;
      end
   endgenerate

endmodule

// File: rtl/regbus_dir_ctrl.sv
module regbus_dir_ctrl (
   input  logic en_n,
   input  logic dir_a2b,
   output logic a_oe,
   output logic b_oe
);

   import regbus_xcvr_pkg::*;

   xcvr_mode_e mode;

   assign mode = decode_mode(en_n, dir_a2b);

   always_comb begin
      a_oe = 1'b0;
      b_oe = 1'b0;
      case (mode)
         XCVR_A_TO_B: b_oe = 1'b1;
         XCVR_B_TO_A: a_oe = 1'b1;
         default: begin
            a_oe = 1'b0;
            b_oe = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             rst_n,
   input  logic             a_cap_clk,
   input  logic             b_cap_clk,
   input  logic             en_n,
   input  logic             dir_a2b,
   input  logic             b_sel_stored,
   input  logic             a_sel_stored,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   localparam int NUM_PORTS = 2;

   initial begin
      assert (WIDTH >= 1 && WIDTH <= 1024) else $error("regbus_xcvr: WIDTH out of range");
      assert (NUM_PORTS == 2) else $error("regbus_xcvr: exactly two ports supported");
   end

   logic [NUM_PORTS-1:0]             cap_clk;
   logic [NUM_PORTS-1:0][WIDTH-1:0]  port_in;
   logic [NUM_PORTS-1:0][WIDTH-1:0]  port_reg;
   logic [NUM_PORTS-1:0]             port_sel;
   logic [NUM_PORTS-1:0][WIDTH-1:0]  port_out;

   // Index 0 is the A side, index 1 the B side.
   assign cap_clk[0] = a_cap_clk;
   assign cap_clk[1] = b_cap_clk;
   assign port_in[0] = a_in;
   assign port_in[1] = b_in;
   // A port output uses B-side data and vice versa.
   assign port_sel[0] = a_sel_stored;
   assign port_sel[1] = b_sel_stored;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_side
         regbus_capture_reg #(.WIDTH(WIDTH)) u_store (
            .clk   (cap_clk[p]),
            .rst_n (rst_n),
            .d     (port_in[p]),
            .q     (port_reg[p])
         );

         regbus_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux (
            .sel_stored (port_sel[p]),
            .live       (port_in[NUM_PORTS-1-p]),
            .stored     (port_reg[NUM_PORTS-1-p]),
            .y          (port_out[p])
         );
      end
   endgenerate

   regbus_dir_ctrl u_dir (
      .en_n    (en_n),
      .dir_a2b (dir_a2b),
      .a_oe    (a_oe),
      .b_oe    (b_oe)
   );

   assign a_out = port_out[0];
   assign b_out = port_out[1];

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input logic             rst_n,
   input logic             a_cap_clk,
   input logic             b_cap_clk,
   input logic             en_n,
   input logic             dir_a2b,
   input logic             b_sel_stored,
   input logic             a_sel_stored,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);

   localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : '0;

   // R10
   oe_exclusive_chk: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
      !(a_oe && b_oe));

   // R4
   isolation_quiet_chk: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
      en_n |-> (!a_oe && !b_oe));

   // R5
   b_drive_dir_chk: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
      (!en_n && dir_a2b) |-> (b_oe && !a_oe));

   // R5
   a_drive_dir_chk: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
      (!en_n && !dir_a2b) |-> (a_oe && !b_oe));

   // R2
   a_store_chk: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
      1'b1 |=> (!b_sel_stored || (b_out == ($past(a_in) ^ FLIP))));

   // R3
   b_store_chk: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
      1'b1 |=> (!a_sel_stored || (a_out == ($past(b_in) ^ FLIP))));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (.*);

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/1ps
module regbus_xcvr_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         a_cap_clk, b_cap_clk;
   logic         en_n, dir_a2b, b_sel_stored, a_sel_stored;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   regbus_xcvr #(.WIDTH(W)) uut (
      .rst_n(rst_n), .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk),
      .en_n(en_n), .dir_a2b(dir_a2b),
      .b_sel_stored(b_sel_stored), .a_sel_stored(a_sel_stored),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive inputs after the falling edge, then let them settle.
   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   // Rising edge on the chosen load clocks, aligned to the bench clock.
   task automatic pulse(input bit pa, input bit pb);
      @(posedge clk);
      a_cap_clk = pa;
      b_cap_clk = pb;
      @(negedge clk);
      a_cap_clk = 1'b0;
      b_cap_clk = 1'b0;
      #1;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      en_n = 1'b0; dir_a2b = 1'b1; b_sel_stored = 1'b1; a_sel_stored = 1'b1;
      a_in = 8'h5A; b_in = 8'hC3;
      settle();
      check("R1 b_out from cleared A register", b_out, 8'hFF);
      check("R1 a_out from cleared B register", a_out, 8'hFF);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic test_live();
      logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
      en_n = 1'b0; b_sel_stored = 1'b0; a_sel_stored = 1'b0;
      foreach (pats[i]) begin
         dir_a2b = 1'b1; a_in = pats[i]; b_in = ~pats[i] ^ 8'h11;
         settle();
         check("R6 live A to B", b_out, ~pats[i]);
         dir_a2b = 1'b0;
         settle();
         check("R7 live B to A", a_out, ~(~pats[i] ^ 8'h11));
      end
   endtask

   task automatic test_store();
      en_n = 1'b0; dir_a2b = 1'b1; b_sel_stored = 1'b1; a_sel_stored = 1'b1;
      a_in = 8'h96; b_in = 8'h00;
      pulse(1'b1, 1'b0);
      a_in = 8'h01;
      settle();
      check("R2 A register holds loaded value", b_out, 8'h69);
      b_in = 8'h4D;
      pulse(1'b0, 1'b1);
      check("R2 b_cap_clk leaves A register", b_out, 8'h69);
      check("R3 B register loaded", a_out, 8'hB2);
      a_in = 8'h7E;
      pulse(1'b1, 1'b0);
      check("R3 a_cap_clk leaves B register", a_out, 8'hB2);
   endtask

   task automatic test_oe();
      for (int g = 0; g < 2; g++) begin
         for (int d = 0; d < 2; d++) begin
            en_n = g[0]; dir_a2b = d[0];
            settle();
            check("R10 enables exclusive", {7'd0, a_oe & b_oe}, 8'd0);
            if (g == 1) begin
               check("R4 isolation a_oe", {7'd0, a_oe}, 8'd0);
               check("R4 isolation b_oe", {7'd0, b_oe}, 8'd0);
            end else begin
               check("R5 a_oe", {7'd0, a_oe}, {7'd0, ~d[0]});
               check("R5 b_oe", {7'd0, b_oe}, {7'd0, d[0]});
            end
         end
      end
   endtask

   task automatic test_isolated_store();
      en_n = 1'b1; dir_a2b = 1'b0;
      a_in = 8'hE1; b_in = 8'h2B;
      pulse(1'b1, 1'b1);
      a_in = 8'h00; b_in = 8'h00;
      settle();
      en_n = 1'b0; dir_a2b = 1'b1; b_sel_stored = 1'b1;
      settle();
      check("R8 stored A visible after isolation", b_out, 8'h1E);
      dir_a2b = 1'b0; a_sel_stored = 1'b1;
      settle();
      check("R8 stored B visible after isolation", a_out, 8'hD4);
   endtask

   task automatic test_select_same_cycle();
      en_n = 1'b0; dir_a2b = 1'b1; b_sel_stored = 1'b1;
      a_in = 8'h33;
      pulse(1'b1, 1'b0);
      a_in = 8'hF0;
      #0.5;
      check("R9 stored before select flip", b_out, 8'hCC);
      b_sel_stored = 1'b0;
      #0.5;
      check("R9 live right after select flip", b_out, 8'h0F);
      a_in = 8'h81;
      #0.5;
      check("R9 live data follows without clock", b_out, 8'h7E);
   endtask

   task automatic test_capture_while_driving();
      en_n = 1'b0; dir_a2b = 1'b1; b_sel_stored = 1'b0;
      @(posedge clk);
      a_in = 8'h6C;
      a_cap_clk = 1'b1;
      #1;
      check("R11 live output during load", b_out, 8'h93);
      @(negedge clk);
      a_cap_clk = 1'b0;
      a_in = 8'h05;
      #1;
      check("R11 live output after load", b_out, 8'hFA);
      b_sel_stored = 1'b1;
      #1;
      check("R11 loaded value via stored source", b_out, 8'h93);
   endtask

   initial begin
      a_cap_clk = 1'b0; b_cap_clk = 1'b0; rst_n = 1'b0;
      en_n = 1'b1; dir_a2b = 1'b0; b_sel_stored = 1'b0; a_sel_stored = 1'b0;
      a_in = '0; b_in = '0;
      test_reset();
      test_live();
      test_store();
      test_oe();
      test_isolated_store();
      test_select_same_cycle();
      test_capture_while_driving();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule